// File: doc/BRIEF.md
# Radix-4 Booth Signed Multiplier

This block multiplies two two's-complement operands of a parameterised width and returns the full double-width signed product. The multiplier operand is recoded in radix 4. Each overlapping three-bit window picks one of five multiples of the multiplicand: zero, plus or minus one times, or plus or minus two times. A plain array would need one row per multiplier bit, so this needs roughly half as many rows.

Each selected multiple becomes a row two bits wider than the operand. A negative multiple is formed by inverting the selected value and adding a one at that row's lowest weight. The rows are sign-extended, placed two bit positions apart, and merged by a chain of 3:2 carry-save compressors. A single carry-propagate adder closes the chain. A parameter picks between a purely combinational result and one that is captured in an output register. Pipelining inside the array is not provided.

Top module: `booth4_mul`

## Requirements
- R1: `product` equals the exact signed product of `mcand` and `mplier`, both read as two's complement, for every pair of operand values.
- R2: Multiplier window (upper, middle, lower) with upper = bit 2k+1, middle = bit 2k and lower = bit 2k-1 maps as follows: 000 and 111 give zero; 001 and 010 give +1x; 011 gives +2x; 100 gives -2x; 101 and 110 give -1x. Row k carries weight 4^k.
- R3: The lowest window takes an implicit 0 below multiplier bit 0, so the first row depends only on multiplier bits 1 and 0.
- R4: A negative selection produces the bitwise inverse of the positive row plus a one added at that row's least significant weight.
- R5: Each row is WIDTH+2 bits wide and is sign-extended to 2*WIDTH bits. This keeps results exact when twice the most negative multiplicand (-2x of -2^(WIDTH-1)) is selected.
- R6: For an odd WIDTH the multiplier is sign-extended by one bit before windowing, and the product stays exact.
- R7: With OUT_REG=1, `product` shows the result for the operands present at a rising `clk` edge from that edge on, and it is 0 while `rst_n` is low. With OUT_REG=0, `product` follows the operands with no clock.
- R8: The most negative value times itself gives +2^(2*WIDTH-2) without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| mcand | input | WIDTH | Signed multiplicand |
| mplier | input | WIDTH | Signed multiplier, recoded in radix 4 |
| product | output | 2*WIDTH | Signed product |

## Verification
The costliest coincidence is a -2x selection on the most negative multiplicand. There the inversion and the injected one of R4 must meet the doubling and the widest sign extension of R5 in the same row. The bench provokes it with the multiplicand at -2^(WIDTH-1) and multiplier window 100 at the bottom and higher up, and with the most negative square. Every operand pair of the default width, and of an odd-width instance, is also swept. Each result is judged against a signed multiply computed in the bench from the operand values.

// File: rtl/booth4_pkg.sv
package booth4_pkg;

   // One radix-4 digit: magnitude selectors and sign
   typedef struct packed {
      logic neg;   // subtract the selected multiple
      logic one;   // select 1x multiplicand
      logic two;   // select 2x multiplicand
   } digit_t;

   // Window {upper, middle, lower} -> digit
   function automatic digit_t recode(input logic [2:0] win);
      digit_t d;
      d.one = win[0] ^ win[1];
      d.two = (win == 3'b011) || (win == 3'b100);
      d.neg = win[2] & ~(win[1] & win[0]);
      return d;
   endfunction

endpackage

// File: rtl/booth4_recoder.sv
module booth4_recoder
   import booth4_pkg::*;
#(
   parameter int GROUPS = 4
) (
   input  logic [2*GROUPS-1:0]  mplier_x,
   output digit_t [GROUPS-1:0]  digits
);

   localparam int XW = 2 * GROUPS + 1;

   // implicit zero below the least significant bit (R3)
   logic [XW-1:0] padded;
   assign padded = {mplier_x, 1'b0};

   for (genvar k = 0; k < GROUPS; k++) begin : g_win
      logic [2:0] win;
      assign win       = padded[2*k +: 3];
      assign digits[k] = recode(win);

      always_comb begin
         if (!$isunknown(win)) begin
            // at most one magnitude selected per digit (R2)
            p_one_mag_r2: assert ($onehot0({digits[k].one, digits[k].two}))
               else $error("digit %0d selects two magnitudes", k);
            // all-equal windows are a zero digit (R2)
            if (win == 3'b000 || win == 3'b111)
               p_zero_win_r2: assert (!digits[k].one && !digits[k].two && !digits[k].neg)
                  else $error("uniform window %0d not zero", k);
         end
      end
   end

endmodule

// File: rtl/booth4_pp_gen.sv
module booth4_pp_gen
   import booth4_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] mcand,
   input  digit_t           dig,
   output logic [WIDTH+1:0] row,
   output logic             inc
);

   localparam int RW = WIDTH + 2;

   logic [RW-1:0] mul1;
   logic [RW-1:0] mul2;
   logic [RW-1:0] mag;

   assign mul1 = RW'($signed(mcand));
   assign mul2 = mul1 << 1;

   always_comb begin
      mag = '0;
      if (dig.one)      mag = mul1;
      else if (dig.two) mag = mul2;
   end

   // inversion here, +1 carried separately to the summer (R4)
   assign row = dig.neg ? ~mag : mag;
   assign inc = dig.neg;

   always_comb begin
      if (!$isunknown({mcand, dig})) begin
         if (!dig.one && !dig.two && !dig.neg)
            p_zero_row_r2: assert (row == '0) else $error("zero digit gave nonzero row");
         if (dig.neg && (dig.one || dig.two))
            p_neg_sign_r4: assert (row[RW-1] == ~mcand[WIDTH-1])
               else $error("negated row sign wrong");
         if (!dig.neg && (dig.one || dig.two))
            p_pos_sign_r5: assert (row[RW-1] == mcand[WIDTH-1])
               else $error("positive row sign wrong");
      end
   end

endmodule

// File: rtl/booth4_csa.sv
module booth4_csa #(
   parameter int W = 16
) (
   input  logic [W-1:0] in_a,
   input  logic [W-1:0] in_b,
   input  logic [W-1:0] in_c,
   output logic [W-1:0] sum,
   output logic [W-1:0] carry
);

   logic [W-1:0] maj;

   for (genvar b = 0; b < W; b++) begin : g_bit
      assign sum[b] = in_a[b] ^ in_b[b] ^ in_c[b];
      assign maj[b] = (in_a[b] & in_b[b]) | (in_a[b] & in_c[b]) | (in_b[b] & in_c[b]);
   end

   // carries move up one weight; the top one drops out (modulo 2^W)
   assign carry = {maj[W-2:0], 1'b0};

endmodule

// File: rtl/booth4_sum.sv
module booth4_sum #(
   parameter int WIDTH  = 8,
   parameter int GROUPS = 4
) (
   input  logic [GROUPS*(WIDTH+2)-1:0] rows,
   input  logic [GROUPS-1:0]           incs,
   output logic [2*WIDTH-1:0]          total
);

   localparam int RW = WIDTH + 2;
   localparam int PW = 2 * WIDTH;

   logic [PW-1:0] placed [GROUPS];
   logic [PW-1:0] corr;
   logic [PW-1:0] s_st   [GROUPS];
   logic [PW-1:0] c_st   [GROUPS];

   // sign-extend each row and place it at weight 4^k (R5)
   for (genvar k = 0; k < GROUPS; k++) begin : g_place
      logic [RW-1:0] r;
      assign r         = rows[k*RW +: RW];
      assign placed[k] = PW'($signed(r)) << (2 * k);
   end

   // +1 injections for negated rows, one per row LSB (R4)
   always_comb begin
      corr = '0;
      for (int k = 0; k < GROUPS; k++)
         if (2 * k < PW) corr[2*k] = incs[k];
   end

   assign s_st[0] = placed[0];
   assign c_st[0] = corr;

   // linear carry-save chain, one 3:2 stage per extra row
   for (genvar k = 1; k < GROUPS; k++) begin : g_chain
      booth4_csa #(.W(PW)) u_csa (
         .in_a  (s_st[k-1]),
         .in_b  (c_st[k-1]),
         .in_c  (placed[k]),
         .sum   (s_st[k]),
         .carry (c_st[k])
      );
   end

   // single carry-propagate adder
   assign total = s_st[GROUPS-1] + c_st[GROUPS-1];

endmodule

// File: rtl/booth4_mul.sv
module booth4_mul
   import booth4_pkg::*;
#(
   parameter int WIDTH   = 8,
   parameter int OUT_REG = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [WIDTH-1:0]     mcand,
   input  logic [WIDTH-1:0]     mplier,
   output logic [2*WIDTH-1:0]   product
);

   localparam int WE     = WIDTH + (WIDTH % 2);
   localparam int GROUPS = WE / 2;
   localparam int RW     = WIDTH + 2;
   localparam int PW     = 2 * WIDTH;

   if (WIDTH < 2) begin : g_bad_width
      $error("booth4_mul: WIDTH must be at least 2");
   end
   if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_reg
      $error("booth4_mul: OUT_REG must be 0 or 1");
   end

   // odd widths gain one sign bit to fill the last window (R6)
   logic [WE-1:0] mplier_x;
   assign mplier_x = WE'($signed(mplier));

   digit_t [GROUPS-1:0]   digits;
   logic [GROUPS*RW-1:0]  rows;
   logic [GROUPS-1:0]     incs;
   logic [PW-1:0]         comb_prod;

   booth4_recoder #(.GROUPS(GROUPS)) u_rec (
      .mplier_x (mplier_x),
      .digits   (digits)
   );

   for (genvar k = 0; k < GROUPS; k++) begin : g_row
      booth4_pp_gen #(.WIDTH(WIDTH)) u_pp (
         .mcand (mcand),
         .dig   (digits[k]),
         .row   (rows[k*RW +: RW]),
         .inc   (incs[k])
      );
   end

   booth4_sum #(.WIDTH(WIDTH), .GROUPS(GROUPS)) u_sum (
      .rows  (rows),
      .incs  (incs),
      .total (comb_prod)
   );

   // first digit depends only on bits 1:0 (R3)
   always_comb begin
      if (!$isunknown(mplier[1:0]) && mplier[1:0] == 2'b00)
         p_low_digit_r3: assert (!digits[0].one && !digits[0].two && !digits[0].neg)
            else $error("lowest digit not zero for bits 00");
   end

   logic signed [PW-1:0] ref_prod;
   assign ref_prod = $signed(mcand) * $signed(mplier);

   if (OUT_REG == 1) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) product <= '0;
         else        product <= comb_prod;
      end

      p_exact_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> (product == $past(ref_prod)))
         else $error("registered product differs from signed multiply");

      p_reset_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(rst_n) |-> (product == '0))
         else $error("product not cleared by reset");
   end else begin : g_comb
      assign product = comb_prod;

      always_comb begin
         if (!$isunknown({mcand, mplier}))
            p_comb_product_r1: assert (product == ref_prod)
               else $error("combinational product differs from signed multiply");
      end
   end

endmodule

// File: tb/tb_booth4_mul.sv
`timescale 1ns/1ps
module tb_booth4_mul;

   localparam int W  = 8;
   localparam int W7 = 7;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [W-1:0]    mcand = '0;
   logic [W-1:0]    mplier = '0;
   logic [2*W-1:0]  product;
   logic [W7-1:0]   mcand7 = '0;
   logic [W7-1:0]   mplier7 = '0;
   logic [2*W7-1:0] product7;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [2*W-1:0] exp_q [$];
   string          tag_q [$];

   always #5 clk = ~clk;

   booth4_mul #(.WIDTH(W), .OUT_REG(1)) dut (
      .clk (clk), .rst_n (rst_n), .mcand (mcand), .mplier (mplier), .product (product)
   );

   booth4_mul #(.WIDTH(W7), .OUT_REG(0)) dut_odd (
      .clk (clk), .rst_n (rst_n), .mcand (mcand7), .mplier (mplier7), .product (product7)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   function automatic logic [2*W-1:0] ref8(input logic [W-1:0] a, input logic [W-1:0] b);
      longint p;
      p = longint'($signed(a)) * longint'($signed(b));
      return p[2*W-1:0];
   endfunction

   function automatic logic [2*W7-1:0] ref7(input logic [W7-1:0] a, input logic [W7-1:0] b);
      longint p;
      p = longint'($signed(a)) * longint'($signed(b));
      return p[2*W7-1:0];
   endfunction

   // driver: applies operands at the falling edge, queues the expected result
   task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
      logic [2*W7-1:0] e7;
      @(negedge clk);
      mcand   = a;
      mplier  = b;
      mcand7  = a[W7-1:0];
      mplier7 = b[W7-1:0];
      exp_q.push_back(ref8(a, b));
      tag_q.push_back(tag);
      #1;
      e7 = ref7(a[W7-1:0], b[W7-1:0]);
      // odd width, combinational variant (R6, R7)
      check(product7 == e7, "R6 odd-width comb", longint'(product7), longint'(e7));
   endtask

   // monitor: compares the registered product after each rising edge (R7 latency)
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            logic [2*W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(product == e, t, longint'(product), longint'(e));
         end
      end
   end

   initial begin
      #(200000 * 10);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R7: product held at 0 during reset even with operands present
      mcand  = 8'h5A;
      mplier = 8'h3C;
      repeat (3) @(posedge clk);
      #2;
      check(product == '0, "R7 reset clears", longint'(product), 0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(product == '0, "R7 reset release", longint'(product), 0);

      drive(8'h80, 8'h80, "R8 min*min");
      drive(8'h80, 8'h02, "R5 -2x of min at window 100");
      drive(8'h80, 8'h20, "R5 -2x of min high row");
      drive(8'h7F, 8'h80, "R1 max*min");
      drive(8'hFF, 8'hFF, "R1 -1*-1");
      drive(8'h00, 8'h80, "R1 zero");
      drive(8'h37, 8'h00, "R1 zero multiplier");
      drive(8'h25, 8'h01, "R3 window 010 lowest");
      drive(8'h25, 8'h03, "R4 window 110 lowest");
      drive(8'hB3, 8'h55, "R2 alternating 01");
      drive(8'hB3, 8'hAA, "R2 alternating 10");
      drive(8'h6D, 8'h66, "R2 mixed windows 011/100");
      drive(8'h40, 8'h7F, "R4 negated rows");
      for (int i = 0; i < 256; i++) begin
         for (int j = 0; j < 256; j++) begin
            drive(8'(i), 8'(j), "R1 sweep");
         end
      end
      @(negedge clk);
      @(negedge clk);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule